// File: doc/BRIEF.md
# Dual-Mode Serial Port

This block is a serial port with two operating modes, chosen by one input. In shift mode it moves 8-bit words over a single data line and drives its own shift clock on the transmit pin. Frame mode is a standard asynchronous link that sends and receives 10-bit frames. In both modes the transmit and receive paths have their own buffer registers. A write always loads the transmit buffer, and the read data port always shows the receive buffer.

In frame mode the bit rate comes from an external timer overflow strobe (`baud_tick`). The receiver samples the line at 16 times the bit rate and uses a three-sample majority vote. The receiver stores the received stop bit in `rb8`. Two sticky flags, `ti` and `ri`, report a finished transmission and a filled receive buffer. Software clears them through one-cycle clear strobes.

In shift mode the shift clock runs at one twelfth of the block clock. The bidirectional data pin is split into `rxd_in`, `rxd_out` and the enable `rxd_oe`.

Top module: `serial_port_core`

## Requirements
- R1: After reset, `ti`, `ri`, `rb8`, `rd_data` and `rxd_oe` are 0, and `txd_out` is 1.
- R2: A write (`wr_en`=1) loads only the transmit buffer. `rd_data` does not change because of a write.
- R3: In frame mode (`frame_mode`=1), a write sends on `txd_out`: a 0 start bit, then the 8 data bits with bit 0 first, then a 1 stop bit. When nothing is being sent, `txd_out` is 1.
- R4: In frame mode, every bit lasts 16 sample ticks. A sample tick is each `baud_tick` when `smod`=1 or `alt_src`=1. Otherwise it is every second `baud_tick`.
- R5: The frame receiver finds a start by seeing `rxd_in` low on a sample tick. It decides each bit by majority vote of samples 7, 8 and 9 of that bit. If the start bit votes 1, the receiver drops it and goes back to waiting.
- R6: When the stop bit of a received frame is decided and `ri`=0, three things happen together: `rd_data` takes the data byte, `rb8` takes the stop bit level, and `ri` is set.
- R7: A reception that completes while `ri`=1 is discarded. `rd_data` and `rb8` keep their values.
- R8: `ti` is set when the last bit of a transmission ends: the stop bit in frame mode, or the 8th bit in shift mode. `ti` and `ri` stay set until `ti_clr` or `ri_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R9: In shift mode (`frame_mode`=0), a write starts a transmit. `txd_out` then carries the shift clock: 12 clock cycles per bit, low for 6 and then high for 6, and 1 when idle. `rxd_oe`=1 and `rxd_out` carries the byte with bit 0 first. `rxd_out` changes only while the shift clock is low.
- R10: In shift mode, a receive starts when `rx_en`=1 and `ri`=0. During a receive `rxd_oe` stays 0. `rxd_in` is sampled at each rising edge of the shift clock, with bit 0 first.
- R11: A write while the transmitter is busy is ignored. The frame in progress completes unchanged, and no second frame follows it.
- R12: In frame mode, transmission and reception run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 1 | 1 = asynchronous frame mode, 0 = shift mode |
| smod | input | 1 | Doubles the frame-mode bit rate |
| alt_src | input | 1 | `baud_tick` is already at 16x the bit rate (no halving) |
| baud_tick | input | 1 | One-cycle timer overflow strobe |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Receive buffer contents |
| rx_en | input | 1 | Receive enable for shift mode |
| ti_clr | input | 1 | Clears `ti` |
| ri_clr | input | 1 | Clears `ri` |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| rb8 | output | 1 | Stop bit of the last accepted frame |
| txd_out | output | 1 | Frame serial output, or the shift clock in shift mode |
| rxd_in | input | 1 | Frame serial input, or shift-mode data input |
| rxd_out | output | 1 | Shift-mode data output |
| rxd_oe | output | 1 | Output enable for `rxd_out` |

## Verification
The assertions check these rules on every cycle:
- the receive buffer holds while `ri` is set;
- the shift clock idles high;
- shift-mode data is steady while the clock is high;
- the frame line idles high;
- `rb8` changes only as `ri` rises;
- each flag rises only right after its transfer engine was active.

Other behaviour needs the bench's scenarios:
- the bit order and frame timing at the three sample-tick rates;
- rejection of a false start, and immunity to a short glitch inside a bit;
- discarding of a frame while `ri` is set;
- an ignored write during a busy transmit;
- full-duplex transfers with random bytes.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_DATA_W = 8;
  localparam int unsigned SP_OSR    = 16;
  localparam int unsigned SP_M0_DIV = 12;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_FRAME = 1'b1
  } sp_mode_e;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_TX   = 2'd1,
    SH_RX   = 2'd2
  } sh_state_e;
endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic smod,
  input  logic alt_src,
  output logic os_tick
);
  logic half_q, half_d;

  always_comb begin
    half_d = half_q;
    if (baud_tick) half_d = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  // every strobe counts when doubled or fed from the fast source, else every second one
  assign os_tick = baud_tick & (smod | alt_src | half_q);
endmodule

// File: rtl/sp_frame_tx.sv
module sp_frame_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              line,
  output logic              busy,
  output logic              done
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CW      = $clog2(OSR);
  localparam int unsigned BW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CW-1:0]      os_q, os_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic               busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    os_d   = os_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        sh_d   = {1'b1, data, 1'b0};
        os_d   = '0;
        bit_d  = '0;
        busy_d = 1'b1;
      end
    end else if (os_tick) begin
      if (os_q == CW'(OSR - 1)) begin
        os_d = '0;
        sh_d = {1'b1, sh_q[FRAME_W-1:1]};
        if (bit_q == BW'(FRAME_W - 1)) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          bit_d = bit_q + BW'(1);
        end
      end else begin
        os_d = os_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      os_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      os_q   <= os_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign line = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/sp_frame_rx.sv
module sp_frame_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              enable,
  input  logic              rxd,
  output logic              load,
  output logic [DATA_W-1:0] data,
  output logic              stop_bit,
  output logic              busy
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CW      = $clog2(OSR);
  localparam int unsigned BW      = $clog2(FRAME_W);
  localparam int unsigned MID     = OSR / 2;

  logic              s1_q, rx_q;
  logic              busy_q, busy_d;
  logic [CW-1:0]     os_q, os_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [1:0]        vote_q, vote_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              stop_q, stop_d;
  logic              bit_val;

  // two of three samples decide
  assign bit_val = (vote_q[0] & vote_q[1]) | (vote_q[0] & rx_q) | (vote_q[1] & rx_q);

  always_comb begin
    busy_d = busy_q;
    os_d   = os_q;
    bit_d  = bit_q;
    vote_d = vote_q;
    sh_d   = sh_q;
    stop_d = stop_q;
    load   = 1'b0;
    if (!busy_q) begin
      if (enable && os_tick && !rx_q) begin
        busy_d = 1'b1;
        os_d   = '0;
        bit_d  = '0;
      end
    end else if (!enable) begin
      busy_d = 1'b0;
    end else if (os_tick) begin
      os_d = (os_q == CW'(OSR - 1)) ? '0 : os_q + CW'(1);
      if (os_q == CW'(MID - 2)) vote_d[0] = rx_q;
      if (os_q == CW'(MID - 1)) vote_d[1] = rx_q;
      if (os_q == CW'(MID)) begin
        if (bit_q == '0) begin
          if (bit_val) busy_d = 1'b0;
        end else if (bit_q == BW'(FRAME_W - 1)) begin
          busy_d = 1'b0;
          stop_d = bit_val;
          load   = 1'b1;
        end else begin
          sh_d = {bit_val, sh_q[DATA_W-1:1]};
        end
      end
      if (os_q == CW'(OSR - 1)) bit_d = bit_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      rx_q   <= 1'b1;
      busy_q <= 1'b0;
      os_q   <= '0;
      bit_q  <= '0;
      vote_q <= '0;
      sh_q   <= '0;
      stop_q <= 1'b0;
    end else begin
      s1_q   <= rxd;
      rx_q   <= s1_q;
      busy_q <= busy_d;
      os_q   <= os_d;
      bit_q  <= bit_d;
      vote_q <= vote_d;
      sh_q   <= sh_d;
      stop_q <= stop_d;
    end
  end

  assign data     = sh_d;
  assign stop_bit = stop_d;
  assign busy     = busy_q;
endmodule

// File: rtl/sp_shift_engine.sv
module sp_shift_engine
  import sp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_start,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_go,
  input  logic              rxd_in,
  output logic              sclk,
  output logic              dout,
  output logic              tx_act,
  output logic              rx_act,
  output logic              tx_done,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int unsigned PW = $clog2(DIV);
  localparam int unsigned BW = $clog2(DATA_W);

  sh_state_e         state_q, state_d;
  logic [PW-1:0]     ph_q, ph_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    tx_done = 1'b0;
    rx_done = 1'b0;
    if (state_q == SH_IDLE) begin
      if (enable && (wr_start || rx_go)) begin
        state_d = wr_start ? SH_TX : SH_RX;
        sh_d    = wr_start ? wr_data : sh_q;
        ph_d    = '0;
        bit_d   = '0;
      end
    end else if (!enable) begin
      state_d = SH_IDLE;
    end else begin
      // receive samples as the clock rises
      if (state_q == SH_RX && ph_q == PW'(DIV / 2 - 1)) sh_d = {rxd_in, sh_q[DATA_W-1:1]};
      if (ph_q == PW'(DIV - 1)) begin
        ph_d = '0;
        if (state_q == SH_TX) sh_d = {1'b0, sh_q[DATA_W-1:1]};
        if (bit_q == BW'(DATA_W - 1)) begin
          state_d = SH_IDLE;
          tx_done = (state_q == SH_TX);
          rx_done = (state_q == SH_RX);
        end else begin
          bit_d = bit_q + BW'(1);
        end
      end else begin
        ph_d = ph_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign tx_act  = (state_q == SH_TX);
  assign rx_act  = (state_q == SH_RX);
  assign sclk    = !((tx_act || rx_act) && (ph_q < PW'(DIV / 2)));
  assign dout    = tx_act ? sh_q[0] : 1'b1;
  assign rx_data = sh_q;
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import sp_pkg::*;
#(
  parameter int unsigned DATA_W = SP_DATA_W,
  parameter int unsigned OSR    = SP_OSR,
  parameter int unsigned M0_DIV = SP_M0_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_mode,
  input  logic              smod,
  input  logic              alt_src,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rx_en,
  input  logic              ti_clr,
  input  logic              ri_clr,
  output logic              ti,
  output logic              ri,
  output logic              rb8,
  output logic              txd_out,
  input  logic              rxd_in,
  output logic              rxd_out,
  output logic              rxd_oe
);
  logic              rst_meta, srst_n;
  sp_mode_e          mode_e;
  logic              os_tick;
  logic              f_line, f_tx_busy, f_tx_done;
  logic              f_load, f_stop, f_rx_busy;
  logic [DATA_W-1:0] f_data;
  logic              m0_sclk, m0_dout, m0_tx_act, m0_rx_act, m0_tx_done, m0_rx_done;
  logic [DATA_W-1:0] m0_data;
  logic              ti_q, ti_d, ri_q, ri_d, rb8_q, rb8_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {srst_n, rst_meta} <= 2'b00;
    else        {srst_n, rst_meta} <= {rst_meta, 1'b1};
  end

  assign mode_e   = sp_mode_e'(frame_mode);
  assign in_frame = (mode_e == MODE_FRAME);

  sp_tick_gen i_tick (
    .clk(clk), .rst_n(srst_n), .baud_tick(baud_tick), .smod(smod),
    .alt_src(alt_src), .os_tick(os_tick)
  );

  sp_frame_tx #(.DATA_W(DATA_W), .OSR(OSR)) i_ftx (
    .clk(clk), .rst_n(srst_n), .os_tick(os_tick),
    .start(wr_en && in_frame), .data(wr_data),
    .line(f_line), .busy(f_tx_busy), .done(f_tx_done)
  );

  sp_frame_rx #(.DATA_W(DATA_W), .OSR(OSR)) i_frx (
    .clk(clk), .rst_n(srst_n), .os_tick(os_tick), .enable(in_frame),
    .rxd(rxd_in), .load(f_load), .data(f_data), .stop_bit(f_stop), .busy(f_rx_busy)
  );

  sp_shift_engine #(.DATA_W(DATA_W), .DIV(M0_DIV)) i_shift (
    .clk(clk), .rst_n(srst_n), .enable(!in_frame), .wr_start(wr_en),
    .wr_data(wr_data), .rx_go(rx_en && !ri_q), .rxd_in(rxd_in),
    .sclk(m0_sclk), .dout(m0_dout), .tx_act(m0_tx_act), .rx_act(m0_rx_act),
    .tx_done(m0_tx_done), .rx_done(m0_rx_done), .rx_data(m0_data)
  );

  always_comb begin
    ti_d   = ti_q;
    ri_d   = ri_q;
    rb8_d  = rb8_q;
    rbuf_d = rbuf_q;
    if (ti_clr) ti_d = 1'b0;
    if (f_tx_done || m0_tx_done) ti_d = 1'b1;
    if (ri_clr) ri_d = 1'b0;
    if ((f_load || m0_rx_done) && !ri_q) begin
      ri_d   = 1'b1;
      rbuf_d = f_load ? f_data : m0_data;
      if (f_load) rb8_d = f_stop;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rb8_q  <= 1'b0;
      rbuf_q <= '0;
    end else begin
      ti_q   <= ti_d;
      ri_q   <= ri_d;
      rb8_q  <= rb8_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign ti      = ti_q;
  assign ri      = ri_q;
  assign rb8     = rb8_q;
  assign rd_data = rbuf_q;
  assign txd_out = in_frame ? f_line : m0_sclk;
  assign rxd_out = m0_dout;
  assign rxd_oe  = m0_tx_act && !in_frame;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              frame_mode,
  input logic              txd_out,
  input logic              rxd_out,
  input logic              rxd_oe,
  input logic              ti,
  input logic              ri,
  input logic              ri_clr,
  input logic              rb8,
  input logic [DATA_W-1:0] rd_data,
  input logic              f_tx_busy,
  input logic              tx_busy,
  input logic              rx_busy,
  input logic              m0_busy,
  input logic              m0_rx_busy
);
  AST_RBUF_HELD: assert property (@(posedge clk) disable iff (!srst_n)
    (ri && !ri_clr) |=> $stable(rd_data)); // R7
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!srst_n)
    (!frame_mode && !m0_busy) |-> txd_out); // R9
  AST_SHIFT_DATA_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (!frame_mode && rxd_oe && $past(rxd_oe) && txd_out && $past(txd_out)) |-> $stable(rxd_out)); // R9
  AST_FRAME_LINE_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    (frame_mode && !f_tx_busy) |-> txd_out); // R3
  AST_RB8_WITH_RI: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(rb8) |-> (ri && !$past(ri))); // R6
  AST_TI_FROM_TX: assert property (@(posedge clk) disable iff (!srst_n)
    (ti && !$past(ti)) |-> $past(tx_busy)); // R8
  AST_RI_FROM_RX: assert property (@(posedge clk) disable iff (!srst_n)
    (ri && !$past(ri)) |-> $past(rx_busy)); // R6
  AST_SHIFT_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!srst_n)
    m0_rx_busy |-> !rxd_oe); // R10
endmodule

bind serial_port_core sp_checker #(.DATA_W(DATA_W)) i_sp_checker (
  .clk(clk), .srst_n(srst_n), .frame_mode(frame_mode), .txd_out(txd_out),
  .rxd_out(rxd_out), .rxd_oe(rxd_oe), .ti(ti), .ri(ri), .ri_clr(ri_clr),
  .rb8(rb8), .rd_data(rd_data), .f_tx_busy(f_tx_busy),
  .tx_busy(f_tx_busy || m0_tx_act), .rx_busy(f_rx_busy || m0_rx_act),
  .m0_busy(m0_tx_act || m0_rx_act), .m0_rx_busy(m0_rx_act)
);

// File: tb/test_serial_port_core.sv
module test_serial_port_core;
  localparam int P   = 4;
  localparam int BLF = 16 * P;
  localparam int BLS = 32 * P;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, frame_mode = 1'b1, smod = 1'b1, alt_src = 1'b0, baud_tick = 1'b0;
  logic       wr_en = 1'b0, rx_en = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0, rxd_in = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ti, ri, rb8, txd_out, rxd_out, rxd_oe;

  int checks = 0, fails = 0, tick_cnt = 0, oe_bad = 0;
  bit done = 1'b0;

  serial_port_core i_serial_port_core (
    .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode), .smod(smod), .alt_src(alt_src),
    .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_en(rx_en), .ti_clr(ti_clr), .ri_clr(ri_clr), .ti(ti), .ri(ri), .rb8(rb8),
    .txd_out(txd_out), .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe)
  );

  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt == P - 1) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == P - 1);
  end

  function automatic logic frame_bit(input logic [7:0] d, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return d[i-1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); ti_clr = 1'b1; ri_clr = 1'b1;
    @(negedge clk); ti_clr = 1'b0; ri_clr = 1'b0;
  endtask

  task automatic m1_send(input logic [7:0] d, input logic stop, input int bl, input bit glitch);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 9) ? stop : frame_bit(d, i);
      rxd_in = v;
      if (glitch) begin
        waitn(bl / 2 - 1); rxd_in = ~v; waitn(2); rxd_in = v; waitn(bl - bl / 2 - 1);
      end else begin
        waitn(bl);
      end
    end
    rxd_in = 1'b1;
  endtask

  task automatic m1_recv(input int bl, output logic [7:0] d, output logic st, output logic sp);
    int t;
    t = 0; d = '0;
    while (txd_out !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    waitn(bl / 2);
    st = txd_out;
    for (int i = 0; i < 8; i++) begin waitn(bl); d[i] = txd_out; end
    waitn(bl);
    sp = txd_out;
  endtask

  task automatic tx_frame_case(input logic [7:0] d, input int bl, input string req);
    logic [7:0] got; logic st, sp;
    fork
      m1_recv(bl, got, st, sp);
      write_byte(d);
    join
    chk({req, " start bit"}, st, frame_bit(d, 0));
    chk({req, " data bits"}, got, d);
    chk({req, " stop bit"}, sp, frame_bit(d, 9));
    waitn(bl / 2 + 2 * P);
    chk("R8 ti after stop bit", ti, 1);
    clear_flags();
  endtask

  task automatic m0_tx_watch(input logic [7:0] d);
    logic prev; logic [7:0] got; int n, t, fall_t, last, bad;
    prev = txd_out; got = '0; n = 0; t = 0; fall_t = 0; last = 0; bad = 0;
    while (n < 8 && t < 3000) begin
      @(negedge clk); t++;
      if (prev && !txd_out) fall_t = t;
      if (!prev && txd_out) begin
        got[n] = rxd_out;
        if (t - fall_t != 6) bad++;
        if (n > 0 && t - last != 12) bad++;
        if (!rxd_oe) bad++;
        last = t; n++;
      end
      prev = txd_out;
    end
    chk("R9 shift tx data LSB first", got, d);
    chk("R9 shift clock 6 low/12 per bit, oe", bad, 0);
  endtask

  task automatic m0_rx_drive(input logic [7:0] d);
    logic prev; int n, t;
    prev = 1'b1; n = 0; t = 0;
    while (n < 8 && t < 3000) begin
      @(negedge clk); t++;
      if (prev && !txd_out) begin rxd_in = d[n]; n++; if (rxd_oe) oe_bad++; end
      prev = txd_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, held;
    logic st, sp;
    int seed, bad;
    seed = int'($urandom(32'd4242));
    waitn(5); rst_n = 1'b1; waitn(4);
    // R1 reset state
    chk("R1 ti", ti, 0); chk("R1 ri", ri, 0); chk("R1 rb8", rb8, 0);
    chk("R1 rd_data", rd_data, 0); chk("R1 txd_out", txd_out, 1); chk("R1 rxd_oe", rxd_oe, 0);

    tx_frame_case(8'hA5, BLF, "R3");
    chk("R2 write leaves rd_data", rd_data, 0);

    m1_send(8'h3C, 1'b1, BLF, 0); waitn(4);
    chk("R6 ri set", ri, 1); chk("R6 rd_data", rd_data, 8'h3C); chk("R6 rb8 stop", rb8, 1);
    waitn(20);
    chk("R8 ri stays until cleared", ri, 1);
    clear_flags();
    chk("R8 flags cleared", {ti, ri}, 0);

    // R12 full duplex with random bytes
    for (int k = 0; k < 4; k++) begin
      logic [7:0] tbyte, rbyte;
      tbyte = 8'($urandom); rbyte = 8'($urandom);
      fork
        m1_recv(BLF, got, st, sp);
        write_byte(tbyte);
        m1_send(rbyte, 1'b1, BLF, 0);
      join
      chk("R12 duplex tx data", {st, got, sp}, {frame_bit(tbyte, 0), tbyte, frame_bit(tbyte, 9)});
      waitn(BLF / 2 + 2 * P);
      chk("R12 duplex rx data", rd_data, rbyte);
      chk("R12 duplex flags", {ti, ri}, 2'b11);
      clear_flags();
    end

    // R4 rate selection
    smod = 1'b0;
    tx_frame_case(8'h0F, BLS, "R4 halved rate");
    alt_src = 1'b1;
    tx_frame_case(8'hF0, BLF, "R4 alternate source");
    alt_src = 1'b0; smod = 1'b1;

    // R11 second write during a busy frame
    fork
      m1_recv(BLF, got, st, sp);
      begin write_byte(8'h5A); waitn(100); write_byte(8'hC3); end
    join
    chk("R11 first frame intact", got, 8'h5A);
    waitn(BLF / 2 + 2 * P);
    bad = 0;
    for (int i = 0; i < 3 * BLF; i++) begin @(negedge clk); if (txd_out !== 1'b1) bad++; end
    chk("R11 no second frame", bad, 0);
    clear_flags();

    // R5 false start and mid-bit glitches
    rxd_in = 1'b0; waitn(3); rxd_in = 1'b1;
    waitn(12 * BLF);
    chk("R5 false start rejected", ri, 0);
    m1_send(8'h96, 1'b1, BLF, 1); waitn(4);
    chk("R5 glitch voted out", {ri, rd_data}, {1'b1, 8'h96});
    clear_flags();

    // R6 stop bit of 0 kept in rb8
    m1_send(8'h81, 1'b0, BLF, 0); rxd_in = 1'b1; waitn(4);
    chk("R6 rb8 low stop", {ri, rb8, rd_data}, {1'b1, 1'b0, 8'h81});
    held = rd_data;
    waitn(2 * BLF);
    // R7 frame while ri set is dropped
    m1_send(8'h77, 1'b1, BLF, 0); waitn(4);
    chk("R7 rd_data kept", rd_data, held);
    chk("R7 rb8 kept", rb8, 0);
    clear_flags();

    // R9 shift mode transmit
    frame_mode = 1'b0; waitn(4);
    chk("R9 shift clock idle high", txd_out, 1);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] sb;
      sb = (k == 0) ? 8'h96 : 8'($urandom);
      fork
        m0_tx_watch(sb);
        write_byte(sb);
      join
      waitn(8);
      chk("R8 ti after 8th shift bit", ti, 1);
      chk("R9 idle after transmit", {rxd_oe, txd_out}, 2'b01);
      clear_flags();
    end

    // R10 shift mode receive
    oe_bad = 0;
    fork
      m0_rx_drive(8'h4D);
      begin @(negedge clk); rx_en = 1'b1; end
    join
    waitn(12);
    rx_en = 1'b0;
    chk("R10 shift rx data", rd_data, 8'h4D);
    chk("R10 shift rx ri", ri, 1);
    chk("R10 rxd_oe low during receive", oe_bad, 0);
    rxd_in = 1'b1;
    clear_flags();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule